// File: doc/BRIEF.md
# Masked SIMD Vector ALU

This block is the arithmetic stage of a vector datapath. It works on a vector of `LANES` elements, each 16 bits wide. Every element can be read as a two's complement integer or as Q.15 fixed point. Q.15 means the sign is in bit 15, bit 14 is worth 2^-1, and each lower bit halves the weight down to 2^-15. Add, subtract and shift produce the same bit pattern in both readings, so one datapath serves both.

Each issued operation takes these inputs:
- two source vectors,
- an opcode,
- a saturation enable,
- a per-element Boolean mask,
- the destination vector's old contents,
- the old contents of the destination mask register.

The result is registered one cycle later, and a new operation may be issued every clock.

Arithmetic results are written only into lanes whose mask bit is set. The other lanes return their old destination value. Compare operations write a per-lane Boolean into the mask output and leave the data vector untouched. The conditional add/subtract uses the mask differently: the mask bit decides, lane by lane, whether that lane adds or subtracts.

Top module: `masked_vec_alu`

## Requirements
- R1: A valid operation presented at a clock edge drives `out_valid` high with its results after that edge, so latency is one cycle. A new operation is accepted every cycle. When `in_valid` is low, `out_valid` drops and `vec_out` and `mask_out` hold their values.
- R2: Opcode 0 computes a+b and opcode 1 computes a-b in each lane. With `sat_en` low the result wraps modulo 2^16. With `sat_en` high a positive overflow gives 0x7FFF and a negative overflow gives 0x8000.
- R3: Opcode 2 negates a. With `sat_en` high, negating 0x8000 gives 0x7FFF. With `sat_en` low it gives 0x8000.
- R4: For opcodes 0, 1, 2, 4, 5, 6 and 7, a lane whose `mask_in` bit (bit i for lane i) is 0 outputs its `dst_old` element unchanged. A lane whose bit is 1 gets the new result.
- R5: Opcode 3 writes every lane. A lane with its mask bit at 1 gets a+b, and a lane with its mask bit at 0 gets a-b. Saturation follows R2.
- R6: Opcode 4 gives the signed maximum of a and b per lane, and opcode 5 gives the signed minimum.
- R7: Opcode 6 shifts a arithmetically by the signed 5-bit amount in b[4:0]. A positive amount shifts left and a negative amount shifts right with sign fill, with -16 giving all sign bits. A left shift that overflows is clamped to 0x7FFF or 0x8000, by the sign of a, when `sat_en` is high.
- R8: Opcode 7 returns, per lane, the number of bits below bit 15 that equal the sign bit before the first bit that differs. The count is in the range 0 to 15, and 0x0000 and 0xFFFF both give 15.
- R9: Opcodes 8 (a==b), 9 (signed a<b) and 10 (signed a<=b) write the comparison result to bit i of `mask_out` in lanes whose `mask_in` bit is 1. Other lanes take their `mask_old` bit. `vec_out` equals `dst_old`.
- R10: For all opcodes other than 8 to 10, `mask_out` equals `mask_old`. Opcodes 11 to 15 write no lane, so `vec_out` equals `dst_old`.
- R11: After reset, `out_valid`, `vec_out` and `mask_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation issued this cycle |
| op_in | input | 4 | Opcode |
| sat_en | input | 1 | Saturate instead of wrapping |
| src_a | input | LANES*16 | First source vector, lane i at bits [16i+15:16i] |
| src_b | input | LANES*16 | Second source vector, or shift amounts |
| mask_in | input | LANES | Per-lane execution mask (also add/sub select for opcode 3) |
| dst_old | input | LANES*16 | Previous destination vector |
| mask_old | input | LANES | Previous destination mask |
| out_valid | output | 1 | Result registered this cycle |
| vec_out | output | LANES*16 | Result vector |
| mask_out | output | LANES | Result mask |

## Verification
The bench drives the overflow corners of add, subtract and negate. A design that wrapped these cases, or clamped with the wrong sign, would return 0x8000 where 0x7FFF is due. The bench uses mixed masks so that a design writing masked-off lanes, or ignoring the mask's add/subtract steering, shows wrong lane values. Shifts by -16 and saturating left shifts expose a logical rather than arithmetic shift or a missed clamp. Leading-sign counts of all-zero and all-one words catch an off-by-one count. A compare that touched the data vector, or wrote masked-off mask bits, is caught as well.

// File: rtl/mvalu_pkg.sv
package mvalu_pkg;
    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_NEG   = 4'd2,
        OP_CADD  = 4'd3,
        OP_MAX   = 4'd4,
        OP_MIN   = 4'd5,
        OP_SHA   = 4'd6,
        OP_LSC   = 4'd7,
        OP_CMPEQ = 4'd8,
        OP_CMPLT = 4'd9,
        OP_CMPLE = 4'd10
    } op_e;

    function automatic logic is_cmp(input logic [3:0] op);
        return (op == OP_CMPEQ) || (op == OP_CMPLT) || (op == OP_CMPLE);
    endfunction

    function automatic logic is_write(input logic [3:0] op);
        return op <= OP_LSC;
    endfunction
endpackage

// File: rtl/vlane_arith.sv
module vlane_arith
    import mvalu_pkg::*;
#(
    parameter int EW = 16
) (
    input  logic [3:0]    op,
    input  logic          sat,
    input  logic          sel,
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    output logic [EW-1:0] res,
    output logic          cmp
);
    localparam logic [EW-1:0] MAXV = {1'b0, {(EW-1){1'b1}}};
    localparam logic [EW-1:0] MINV = {1'b1, {(EW-1){1'b0}}};

    logic [EW-1:0] lhs_d, rhs_d, arith_d;
    logic [EW:0]   sum_d;
    logic          sub_d, ovf_d, lt_d, eq_d;

    always_comb begin
        lhs_d = (op == OP_NEG) ? '0 : a;
        rhs_d = (op == OP_NEG) ? a : b;
        sub_d = (op == OP_SUB) || (op == OP_NEG) || ((op == OP_CADD) && !sel);
        if (sub_d) sum_d = {lhs_d[EW-1], lhs_d} - {rhs_d[EW-1], rhs_d};
        else       sum_d = {lhs_d[EW-1], lhs_d} + {rhs_d[EW-1], rhs_d};
        ovf_d   = sum_d[EW] ^ sum_d[EW-1];
        arith_d = (sat && ovf_d) ? (sum_d[EW] ? MINV : MAXV) : sum_d[EW-1:0];
        lt_d    = $signed(a) < $signed(b);
        eq_d    = (a == b);
        case (op)
            OP_MAX:  res = lt_d ? b : a;
            OP_MIN:  res = lt_d ? a : b;
            default: res = arith_d;
        endcase
        case (op)
            OP_CMPEQ: cmp = eq_d;
            OP_CMPLT: cmp = lt_d;
            OP_CMPLE: cmp = lt_d | eq_d;
            default:  cmp = 1'b0;
        endcase
    end
endmodule

// File: rtl/vlane_shift.sv
module vlane_shift #(
    parameter int EW  = 16,
    parameter int SHW = $clog2(EW) + 1
) (
    input  logic           sat,
    input  logic [EW-1:0]  a,
    input  logic [SHW-1:0] amt,
    output logic [EW-1:0]  sh_res,
    output logic [EW-1:0]  lsc_res
);
    localparam logic [EW-1:0] MAXV = {1'b0, {(EW-1){1'b1}}};
    localparam logic [EW-1:0] MINV = {1'b1, {(EW-1){1'b0}}};

    logic [2*EW-1:0]      ext_d, wide_d;
    logic [EW:0]          top_d;
    logic                 ovf_d, run_d;
    logic [SHW-1:0]       rsh_d;
    logic signed [EW-1:0] sa_d, shr_d;
    logic [EW-1:0]        cnt_d;

    always_comb begin
        ext_d  = {{EW{a[EW-1]}}, a};
        wide_d = ext_d << amt[SHW-2:0];
        top_d  = wide_d[2*EW-1:EW-1];
        ovf_d  = !((&top_d) || !(|top_d));
        rsh_d  = -amt;
        sa_d   = a;
        shr_d  = sa_d >>> rsh_d;
        if (amt[SHW-1])      sh_res = shr_d;
        else if (sat && ovf_d) sh_res = a[EW-1] ? MINV : MAXV;
        else                 sh_res = wide_d[EW-1:0];

        cnt_d = '0;
        run_d = 1'b1;
        for (int i = EW - 2; i >= 0; i--) begin
            if (run_d && (a[i] == a[EW-1])) cnt_d = cnt_d + {{(EW-1){1'b0}}, 1'b1};
            else                            run_d = 1'b0;
        end
        lsc_res = cnt_d;
    end
endmodule

// File: rtl/vlane.sv
module vlane
    import mvalu_pkg::*;
#(
    parameter int EW = 16
) (
    input  logic [3:0]    op,
    input  logic          sat,
    input  logic          msk,
    input  logic          mold,
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    input  logic [EW-1:0] dst,
    output logic [EW-1:0] lane_vec,
    output logic          lane_msk
);
    localparam int SHW = $clog2(EW) + 1;

    logic [EW-1:0] ar_res, sh_res, lsc_res, pick_d;
    logic          cmp_res, we_d;

    vlane_arith #(.EW(EW)) u_arith (
        .op(op), .sat(sat), .sel(msk), .a(a), .b(b), .res(ar_res), .cmp(cmp_res)
    );

    vlane_shift #(.EW(EW), .SHW(SHW)) u_shift (
        .sat(sat), .a(a), .amt(b[SHW-1:0]), .sh_res(sh_res), .lsc_res(lsc_res)
    );

    always_comb begin
        case (op)
            OP_SHA:  pick_d = sh_res;
            OP_LSC:  pick_d = lsc_res;
            default: pick_d = ar_res;
        endcase
        we_d     = is_write(op) && (msk || (op == OP_CADD));
        lane_vec = we_d ? pick_d : dst;
        lane_msk = (is_cmp(op) && msk) ? cmp_res : mold;
    end
endmodule

// File: rtl/masked_vec_alu.sv
module masked_vec_alu #(
    parameter int LANES = 4,
    parameter int EW    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [3:0]          op_in,
    input  logic                sat_en,
    input  logic [LANES*EW-1:0] src_a,
    input  logic [LANES*EW-1:0] src_b,
    input  logic [LANES-1:0]    mask_in,
    input  logic [LANES*EW-1:0] dst_old,
    input  logic [LANES-1:0]    mask_old,
    output logic                out_valid,
    output logic [LANES*EW-1:0] vec_out,
    output logic [LANES-1:0]    mask_out
);
    localparam int N = LANES * EW;

    typedef struct packed {
        logic [N-1:0]     vec;
        logic [LANES-1:0] msk;
        logic             vld;
    } st_t;

    st_t              st_d, st_q;
    logic [N-1:0]     lane_vec;
    logic [LANES-1:0] lane_msk;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vlane #(.EW(EW)) u_lane (
            .op(op_in), .sat(sat_en), .msk(mask_in[i]), .mold(mask_old[i]),
            .a(src_a[i*EW +: EW]), .b(src_b[i*EW +: EW]), .dst(dst_old[i*EW +: EW]),
            .lane_vec(lane_vec[i*EW +: EW]), .lane_msk(lane_msk[i])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.vec = lane_vec;
            st_d.msk = lane_msk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign vec_out   = st_q.vec;
    assign mask_out  = st_q.msk;
endmodule

// File: rtl/masked_vec_alu_chk.sv
module masked_vec_alu_chk #(
    parameter int LANES = 4,
    parameter int EW    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [3:0]          op_in,
    input logic [LANES-1:0]    mask_in,
    input logic [LANES*EW-1:0] dst_old,
    input logic [LANES-1:0]    mask_old,
    input logic                out_valid,
    input logic [LANES*EW-1:0] vec_out,
    input logic [LANES-1:0]    mask_out
);
    logic [LANES*EW-1:0] keep_x;
    logic                lsc_ok, masked_op, cmp_op;

    always_comb begin
        lsc_ok = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            keep_x[i*EW +: EW] = {EW{!mask_in[i]}};
            if (vec_out[i*EW+4 +: EW-4] != '0) lsc_ok = 1'b0;
        end
        masked_op = (op_in <= 4'd7) && (op_in != 4'd3);
        cmp_op    = (op_in >= 4'd8) && (op_in <= 4'd10);
    end

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(vec_out) && $stable(mask_out)));
    assert_masked_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && masked_op) |=> (((vec_out ^ $past(dst_old)) & $past(keep_x)) == '0));
    assert_lsc_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_in == 4'd7 && (&mask_in)) |=> lsc_ok);
    assert_cmp_vec_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cmp_op) |=> (vec_out == $past(dst_old)));
    assert_mask_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cmp_op) |=> (mask_out == $past(mask_old)));
endmodule

bind masked_vec_alu masked_vec_alu_chk #(.LANES(LANES), .EW(EW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_in(op_in),
    .mask_in(mask_in), .dst_old(dst_old), .mask_old(mask_old),
    .out_valid(out_valid), .vec_out(vec_out), .mask_out(mask_out)
);

// File: tb/masked_vec_alu_bench.sv
`timescale 1ns/1ps
module masked_vec_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_in = '0;
    logic        sat_en = 1'b0;
    logic [63:0] src_a = '0, src_b = '0, dst_old = '0;
    logic [3:0]  mask_in = '0, mask_old = '0;
    logic        out_valid;
    logic [63:0] vec_out;
    logic [3:0]  mask_out;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    masked_vec_alu u_masked_vec_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_in(op_in), .sat_en(sat_en),
        .src_a(src_a), .src_b(src_b), .mask_in(mask_in), .dst_old(dst_old),
        .mask_old(mask_old), .out_valid(out_valid), .vec_out(vec_out), .mask_out(mask_out)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic s, input logic [63:0] a,
                         input logic [63:0] b, input logic [3:0] m,
                         input logic [63:0] d, input logic [3:0] mo);
        op_in = op; sat_en = s; src_a = a; src_b = b; mask_in = m;
        dst_old = d; mask_old = mo; in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 valid", {63'd0, out_valid}, 64'd0);
        chk("R11 vec", vec_out, 64'd0);
        chk("R11 mask", {60'd0, mask_out}, 64'd0);
    endtask

    task automatic t_addsub;
        issue(4'd0, 1'b0, 64'h7FFF_0001_FFFF_1234, 64'h0001_0002_0001_1111, 4'hF, 64'd0, 4'h6);
        chk("R2 add wrap", vec_out, 64'h8000_0003_0000_2345);
        chk("R1 valid", {63'd0, out_valid}, 64'd1);
        chk("R10 mask pass", {60'd0, mask_out}, 64'h6);
        issue(4'd0, 1'b1, 64'h7FFF_0001_FFFF_1234, 64'h0001_0002_0001_1111, 4'hF, 64'd0, 4'h0);
        chk("R2 add sat", vec_out, 64'h7FFF_0003_0000_2345);
        issue(4'd1, 1'b1, 64'h8000_0005_7FFF_0000, 64'h0001_0007_FFFF_0001, 4'hF, 64'd0, 4'h0);
        chk("R2 sub sat", vec_out, 64'h8000_FFFE_7FFF_FFFF);
    endtask

    task automatic t_mask;
        issue(4'd0, 1'b1, 64'h0001_0001_0001_0001, 64'h0001_0001_0001_0001, 4'b0101,
              64'hAAAA_BBBB_CCCC_DDDD, 4'h0);
        chk("R4 masked add", vec_out, 64'hAAAA_0002_CCCC_0002);
    endtask

    task automatic t_neg;
        issue(4'd2, 1'b1, 64'h8000_0001_0000_FFFF, 64'd0, 4'hF, 64'd0, 4'h0);
        chk("R3 neg sat", vec_out, 64'h7FFF_FFFF_0000_0001);
        issue(4'd2, 1'b0, 64'h8000_0001_0000_FFFF, 64'd0, 4'hF, 64'd0, 4'h0);
        chk("R3 neg wrap", vec_out, 64'h8000_FFFF_0000_0001);
    endtask

    task automatic t_cadd;
        issue(4'd3, 1'b0, 64'h0010_0010_0010_0010, 64'h0003_0003_0003_0003, 4'b0011,
              64'h5555_5555_5555_5555, 4'h0);
        chk("R5 cond add/sub", vec_out, 64'h000D_000D_0013_0013);
    endtask

    task automatic t_maxmin;
        issue(4'd4, 1'b0, 64'h8000_0005_FFFF_7FFF, 64'h7FFF_0005_0001_8000, 4'hF, 64'd0, 4'h0);
        chk("R6 max", vec_out, 64'h7FFF_0005_0001_7FFF);
        issue(4'd5, 1'b0, 64'h8000_0005_FFFF_7FFF, 64'h7FFF_0005_0001_8000, 4'hF, 64'd0, 4'h0);
        chk("R6 min", vec_out, 64'h8000_0005_FFFF_8000);
    endtask

    task automatic t_shift;
        issue(4'd6, 1'b0, 64'hF000_8000_4000_0001, 64'h0010_001F_0001_0004, 4'hF, 64'd0, 4'h0);
        chk("R7 shift wrap", vec_out, 64'hFFFF_C000_8000_0010);
        issue(4'd6, 1'b1, 64'hF000_8000_4000_0001, 64'h0010_001F_0001_0004, 4'hF, 64'd0, 4'h0);
        chk("R7 shift sat", vec_out, 64'hFFFF_C000_7FFF_0010);
        issue(4'd6, 1'b1, 64'h0000_0000_0000_C000, 64'h0000_0000_0000_0002, 4'hF, 64'd0, 4'h0);
        chk("R7 shift sat neg", vec_out, 64'h0000_0000_0000_8000);
    endtask

    task automatic t_lsc;
        issue(4'd7, 1'b0, 64'h0000_FFFF_0001_4000, 64'd0, 4'hF, 64'd0, 4'h0);
        chk("R8 lsc", vec_out, 64'h000F_000F_000E_0000);
    endtask

    task automatic t_cmp;
        issue(4'd9, 1'b0, 64'h0001_8000_0005_0003, 64'h0002_0001_0005_0003, 4'b1110,
              64'h1111_2222_3333_4444, 4'b0001);
        chk("R9 lt mask", {60'd0, mask_out}, 64'hD);
        chk("R9 vec kept", vec_out, 64'h1111_2222_3333_4444);
        issue(4'd8, 1'b0, 64'h0001_8000_0005_0003, 64'h0002_0001_0005_0003, 4'hF, 64'd0, 4'h0);
        chk("R9 eq mask", {60'd0, mask_out}, 64'h3);
        issue(4'd10, 1'b0, 64'h0001_8000_0005_0003, 64'h0002_0001_0005_0003, 4'hF, 64'd0, 4'h0);
        chk("R9 le mask", {60'd0, mask_out}, 64'hF);
    endtask

    task automatic t_undef;
        issue(4'd12, 1'b1, 64'h1234_1234_1234_1234, 64'h1, 4'hF, 64'h9999_8888_7777_6666, 4'hA);
        chk("R10 undef vec", vec_out, 64'h9999_8888_7777_6666);
        chk("R10 undef mask", {60'd0, mask_out}, 64'hA);
    endtask

    task automatic t_pipe;
        op_in = 4'd0; sat_en = 1'b0; src_a = 64'h1; src_b = 64'h1; mask_in = 4'hF;
        dst_old = '0; mask_old = '0; in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 back1", vec_out, 64'h2);
        op_in = 4'd1; src_a = 64'h5; src_b = 64'h7;
        @(posedge clk); @(negedge clk);
        chk("R1 back2", vec_out, 64'h0000_0000_0000_FFFE);
        in_valid = 1'b0; src_a = 64'h77;
        @(posedge clk); @(negedge clk);
        chk("R1 idle valid", {63'd0, out_valid}, 64'd0);
        chk("R1 idle hold", vec_out, 64'h0000_0000_0000_FFFE);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_addsub();
        t_mask();
        t_neg();
        t_cadd();
        t_maxmin();
        t_shift();
        t_lsc();
        t_cmp();
        t_undef();
        t_pipe();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule